// File: doc/BRIEF.md
# Two-Wire Register Slave with Range-Dependent Pointer Advance

This block is the serial front end of a display-controller register file. It watches already-synchronised samples of a two-wire bus (clock and data), recognises START, repeated START and STOP, and answers to one 7-bit device address. The upper three address bits are fixed. The lower four come from two 2-bit strap inputs. It drives the data line only through an open-drain enable: 1 means pull low.

After its address with a write direction, the block takes the first byte as a register pointer. It passes every following byte to an external register-bus port at that pointer. After its address with a read direction, it fetches bytes from the port at the stored pointer and shifts them out.

After every byte read or written, the pointer moves by a per-range rule:
- In most ranges it steps up by one.
- At the font-access register it holds, and a separate font pointer steps up instead.
- At the top address it saturates.

Writes to the reserved register never reach the bus.

Top module: `twi_regslave`

## Requirements
- R1: The block answers only to address {1,0,1,strap_hi_i,strap_lo_i} (MSB first), where each strap is coded GND=00, V+=01, SDA=10, SCL=11. For any other address it gives no ACK and makes no register access until the next START or STOP.
- R2: The block pulls SDA low during the ninth clock after each of these bytes: a matching address byte, a command byte, and every written data byte. The eighth address bit selects the direction: 0 is a write and 1 is a read.
- R3: In a write, the first byte after the address loads the pointer from its low seven bits; its MSB is ignored. A STOP right after this byte leaves the pointer stored and makes no register write.
- R4: Each written data byte goes out as a one-cycle reg_wr_o strobe with reg_addr_o set to the pointer. Each read byte is taken from reg_rdata_i at a one-cycle reg_rd_o strobe and sent MSB first.
- R5: After each byte read or written at pointer 0x00 to 0x04 or 0x06 to 0x7E, the pointer steps up by one.
- R6: After a byte read or written at pointer 0x05, the pointer stays 0x05 and font_ptr_o steps up by one. At pointer 0x7F the pointer stays 0x7F.
- R7: A data byte written while the pointer is 0x06 produces no reg_wr_o strobe.
- R8: START is SDA falling while SCL is high; STOP is SDA rising while SCL is high. sda_oe_o changes only while SCL is low, and a STOP releases it.
- R9: A repeated START keeps the stored pointer, so a following read starts at the pointer just written.
- R10: When the master NACKs a read byte, the block releases SDA and ignores clocks until STOP or START.
- R11: After reset, sda_oe_o is 0, the pointer is 0x00, font_ptr_o is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock sample |
| sda_i | input | 1 | Synchronised bus data sample |
| sda_oe_o | output | 1 | Open-drain data enable, 1 pulls SDA low |
| strap_hi_i | input | 2 | Strap code for address bits 3:2 |
| strap_lo_i | input | 2 | Strap code for address bits 1:0 |
| reg_addr_o | output | PTR_W | Register address (the pointer) |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid in the strobe cycle |
| font_ptr_o | output | FONT_PTR_W | Font pointer, steps on each access at 0x05 |

## Verification
The embedded properties check, on every cycle:
- the pointer step after each byte outside the hold addresses;
- the pointer hold and font-pointer step at the font register, and saturation at the top address;
- the absence of writes to the reserved address;
- that the data enable stays steady while SCL is high, and that it is released after a STOP, in the idle state and in the ignore state.

Only the bench's bus scenarios can show the following:
- address matching across strap codes;
- the MSB of the command byte being dropped;
- a pointer-only write followed by a read;
- the pointer surviving a repeated START;
- the bytes actually shifted out during multi-byte reads.

// File: rtl/twi_pkg.sv
package twi_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_CMD,
      ST_WR,
      ST_RD,
      ST_RACK,
      ST_WAIT
   } twi_state_e;

   typedef enum logic [1:0] {
      K_ADDR,
      K_CMD,
      K_DATA
   } ack_kind_e;
endpackage

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/twi_addr_match.sv
module twi_addr_match #(
   parameter int PREFIX_W = 3,
   parameter logic [PREFIX_W-1:0] PREFIX = 3'b101,
   parameter int STRAP_N = 2,
   localparam int STRAP_BITS = 2 * STRAP_N
) (
   input  logic [STRAP_BITS-1:0] straps_i,
   input  logic [7:0]            byte_i,
   output logic                  match_o
);
   logic [STRAP_BITS-1:0] low_bits;

   if (PREFIX_W + STRAP_BITS != 7) begin : g_bad_width
      $error("prefix and straps must form a 7-bit address");
   end

   for (genvar g = 0; g < STRAP_N; g++) begin : g_strap
      assign low_bits[2*g +: 2] = straps_i[2*g +: 2];
   end

   assign match_o = (byte_i[7:1] == {PREFIX, low_bits});
endmodule

// File: rtl/twi_ptr_step.sv
module twi_ptr_step #(
   parameter int PTR_W = 7,
   parameter logic [PTR_W-1:0] FONT_REG = 7'h05,
   parameter bit SATURATE_TOP = 1'b1
) (
   input  logic [PTR_W-1:0] ptr_i,
   output logic [PTR_W-1:0] ptr_next_o,
   output logic             font_step_o
);
   localparam logic [PTR_W-1:0] TOP_PTR = '1;

   assign font_step_o = (ptr_i == FONT_REG);

   if (SATURATE_TOP) begin : g_sat
      assign ptr_next_o = (font_step_o || ptr_i == TOP_PTR) ? ptr_i : ptr_i + 1'b1;
   end else begin : g_wrap
      assign ptr_next_o = font_step_o ? ptr_i : ptr_i + 1'b1;
   end
endmodule

// File: rtl/twi_regslave.sv
module twi_regslave
   import twi_pkg::*;
#(
   parameter int PTR_W = 7,
   parameter int FONT_PTR_W = 7,
   parameter logic [PTR_W-1:0] FONT_REG = 7'h05,
   parameter logic [PTR_W-1:0] RSVD_REG = 7'h06,
   parameter bit SATURATE_TOP = 1'b1,
   parameter logic [2:0] ADDR_PREFIX = 3'b101
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe_o,
   input  logic [1:0]            strap_hi_i,
   input  logic [1:0]            strap_lo_i,
   output logic [PTR_W-1:0]      reg_addr_o,
   output logic                  reg_wr_o,
   output logic [BYTE_W-1:0]     reg_wdata_o,
   output logic                  reg_rd_o,
   input  logic [BYTE_W-1:0]     reg_rdata_i,
   output logic [FONT_PTR_W-1:0] font_ptr_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
   localparam logic [PTR_W-1:0] TOP_PTR = '1;

   if (PTR_W < 3 || PTR_W > BYTE_W - 1) begin : g_bad_ptr
      $error("PTR_W must lie between 3 and 7");
   end
   if (FONT_REG == RSVD_REG) begin : g_bad_regs
      $error("font and reserved registers must differ");
   end

   twi_state_e state;
   ack_kind_e kind;
   logic rw_q, nack_q, oe_q;
   logic [CNT_W-1:0] bitcnt;
   logic [BYTE_W-1:0] shreg, tx_q;
   logic [PTR_W-1:0] ptr_q, ptr_next;
   logic [FONT_PTR_W-1:0] font_q;
   logic start_det, stop_det, scl_rise, scl_fall;
   logic addr_ok, font_step;
   logic wr_done, wr_stb, rd_stb, byte_adv;

   twi_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .start_o(start_det), .stop_o(stop_det),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
   );

   twi_addr_match #(.PREFIX_W(3), .PREFIX(ADDR_PREFIX), .STRAP_N(2)) u_match (
      .straps_i({strap_hi_i, strap_lo_i}), .byte_i(shreg), .match_o(addr_ok)
   );

   twi_ptr_step #(.PTR_W(PTR_W), .FONT_REG(FONT_REG), .SATURATE_TOP(SATURATE_TOP)) u_step (
      .ptr_i(ptr_q), .ptr_next_o(ptr_next), .font_step_o(font_step)
   );

   assign wr_done  = (state == ST_WR) && scl_fall && (bitcnt == CNT_FULL);
   assign wr_stb   = wr_done && (ptr_q != RSVD_REG);
   assign rd_stb   = scl_fall && (((state == ST_ACK) && (kind == K_ADDR) && rw_q) ||
                                  ((state == ST_RACK) && !nack_q));
   assign byte_adv = wr_done || rd_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind   <= K_ADDR;
         rw_q   <= 1'b0;
         nack_q <= 1'b0;
         oe_q   <= 1'b0;
         bitcnt <= '0;
         shreg  <= '0;
         tx_q   <= '0;
         ptr_q  <= '0;
         font_q <= '0;
      end else if (start_det) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         oe_q   <= 1'b0;
      end else if (stop_det) begin
         state <= ST_IDLE;
         oe_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_CMD, ST_WR: begin
               if (scl_rise && bitcnt != CNT_FULL) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_i};
                  bitcnt <= bitcnt + 1'b1;
               end else if (scl_fall && bitcnt == CNT_FULL) begin
                  if (state == ST_ADDR) begin
                     if (addr_ok) begin
                        rw_q  <= shreg[0];
                        kind  <= K_ADDR;
                        oe_q  <= 1'b1;
                        state <= ST_ACK;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end else begin
                     if (state == ST_CMD) begin
                        ptr_q <= shreg[PTR_W-1:0];
                        kind  <= K_CMD;
                     end else begin
                        kind <= K_DATA;
                     end
                     oe_q  <= 1'b1;
                     state <= ST_ACK;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rd_stb) begin
                     tx_q  <= reg_rdata_i;
                     oe_q  <= ~reg_rdata_i[BYTE_W-1];
                     state <= ST_RD;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= (kind == K_ADDR) ? ST_CMD : ST_WR;
                  end
               end
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (bitcnt == CNT_LAST) begin
                     oe_q   <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_RACK;
                  end else begin
                     tx_q   <= tx_q << 1;
                     oe_q   <= ~tx_q[BYTE_W-2];
                     bitcnt <= bitcnt + 1'b1;
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack_q <= sda_i;
               end else if (scl_fall) begin
                  if (rd_stb) begin
                     tx_q  <= reg_rdata_i;
                     oe_q  <= ~reg_rdata_i[BYTE_W-1];
                     state <= ST_RD;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
         if (byte_adv) begin
            ptr_q <= ptr_next;
            if (font_step) font_q <= font_q + 1'b1;
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign reg_addr_o  = ptr_q;
   assign reg_wr_o    = wr_stb;
   assign reg_wdata_o = shreg;
   assign reg_rd_o    = rd_stb;
   assign font_ptr_o  = font_q;

   // R5: ordinary ranges step the pointer by one
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      byte_adv && ptr_q != FONT_REG && ptr_q != TOP_PTR |=> ptr_q == $past(ptr_q) + 1'b1);

   // R6: font register holds the pointer and steps the font pointer
   a_r6_font_hold: assert property (@(posedge clk) disable iff (!rst_n)
      byte_adv && ptr_q == FONT_REG |=> ptr_q == FONT_REG && font_ptr_o == $past(font_ptr_o) + 1'b1);

   // R6: the top address saturates
   a_r6_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
      SATURATE_TOP && byte_adv && ptr_q == TOP_PTR |=> ptr_q == TOP_PTR);

   // R7: no write strobe while the pointer sits on the reserved address
   a_r7_no_rsvd_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |-> reg_addr_o != RSVD_REG);

   // R4: at most one register strobe per cycle
   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr_o, reg_rd_o}));

   // R8: data enable steady while SCL is high
   a_r8_sda_hold: assert property (@(posedge clk) disable iff (!rst_n)
      scl_i && $past(scl_i) |-> $stable(sda_oe_o));

   // R8: STOP releases the data line
   a_r8_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);

   // R10: idle and ignore states never drive the line
   a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_WAIT) |-> !sda_oe_o);
endmodule

// File: tb/twi_regslave_bench.sv
module twi_regslave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic [1:0] s_hi = 2'b00, s_lo = 2'b00;
   logic sda_oe, reg_wr, reg_rd;
   logic [6:0] reg_addr, font_ptr;
   logic [7:0] reg_wdata, reg_rdata;
   logic sda_line;

   logic [7:0] rf [128];
   logic [127:0] wmask;
   int wr_cnt;
   logic [6:0] last_wa;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   twi_regslave u_twi_regslave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .strap_hi_i(s_hi), .strap_lo_i(s_lo),
      .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
      .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata), .font_ptr_o(font_ptr)
   );

   // external register file model: unwritten locations read as address ^ 0xA5
   assign reg_rdata = wmask[reg_addr] ? rf[reg_addr] : ({1'b0, reg_addr} ^ 8'hA5);

   always @(posedge clk) begin
      if (!rst_n) begin
         wmask  <= '0;
         wr_cnt <= 0;
         last_wa <= '0;
      end else if (reg_wr) begin
         rf[reg_addr]    <= reg_wdata;
         wmask[reg_addr] <= 1'b1;
         wr_cnt  <= wr_cnt + 1;
         last_wa <= reg_addr;
      end
   end

   // {hi,lo,expect_ack,000} | address byte (write) | command byte | data byte
   localparam logic [31:0] VEC [8] = '{
      32'h08A0_2155, 32'h68AC_403C, 32'hF8BE_A381, 32'h98B2_010F,
      32'h00A2_2277, 32'h506A_2299, 32'hC8B8_7EE7, 32'h70BA_1011
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      m_sda = 1'b1; waitc(4);
      scl = 1'b1;   waitc(4);
      m_sda = 1'b0; waitc(4);
      scl = 1'b0;   waitc(4);
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; waitc(4);
      scl = 1'b1;   waitc(4);
      m_sda = 1'b1; waitc(4);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; waitc(4);
         scl = 1'b1;   waitc(4);
         scl = 1'b0;
      end
      m_sda = 1'b1; waitc(4);
      scl = 1'b1;   waitc(2);
      ack = !sda_line; waitc(2);
      scl = 1'b0;   waitc(4);
   endtask

   task automatic recv_byte(input bit m_ack, output logic [7:0] d);
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         waitc(4);
         scl = 1'b1; waitc(2);
         d = {d[6:0], sda_line}; waitc(2);
         scl = 1'b0;
      end
      waitc(2);
      m_sda = !m_ack; waitc(2);
      scl = 1'b1; waitc(4);
      scl = 1'b0; waitc(2);
      m_sda = 1'b1; waitc(2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin : main
      bit ack;
      logic [7:0] d;
      int base;
      waitc(5);
      rst_n = 1'b1;
      waitc(2);
      // R11 reset state
      check(sda_oe == 1'b0, "R11 oe", sda_oe, 0);
      check(font_ptr == 7'd0, "R11 font", font_ptr, 0);
      check(reg_wr == 1'b0 && reg_rd == 1'b0, "R11 strobes", {reg_wr, reg_rd}, 0);

      // R11: pointer starts at 0x00, read returns register 0
      bus_start();
      send_byte(8'hA1, ack);
      check(ack, "R2 read address ack", ack, 1);
      recv_byte(1'b0, d);
      check(d == 8'hA5, "R11 pointer reset read", d, 8'hA5);
      bus_stop();

      // R1 R2 R3 R4: table of strap/address/command/data vectors
      for (int v = 0; v < 8; v++) begin
         s_hi = VEC[v][31:30];
         s_lo = VEC[v][29:28];
         base = wr_cnt;
         bus_start();
         send_byte(VEC[v][23:16], ack);
         check(ack == VEC[v][27], "R1 address match", ack, VEC[v][27]);
         if (VEC[v][27]) begin
            send_byte(VEC[v][15:8], ack);
            check(ack, "R2 command ack", ack, 1);
            send_byte(VEC[v][7:0], ack);
            check(ack, "R2 data ack", ack, 1);
            bus_stop();
            check(rf[VEC[v][14:8]] == VEC[v][7:0] && wmask[VEC[v][14:8]],
                  "R4 R3 write at pointer", rf[VEC[v][14:8]], VEC[v][7:0]);
         end else begin
            send_byte(VEC[v][15:8], ack);
            check(!ack && sda_oe == 1'b0, "R1 ignored after mismatch", ack, 0);
            bus_stop();
            check(wr_cnt == base, "R1 no access", wr_cnt - base, 0);
         end
      end
      s_hi = 2'b00;
      s_lo = 2'b00;

      // R5: autoincrement over a multi-byte write
      base = wr_cnt;
      bus_start(); send_byte(8'hA0, ack); send_byte(8'h10, ack);
      send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
      bus_stop();
      check(rf[7'h10] == 8'h11 && rf[7'h11] == 8'h22 && rf[7'h12] == 8'h33,
            "R5 increment", rf[7'h12], 8'h33);
      check(wr_cnt == base + 3, "R5 write count", wr_cnt - base, 3);

      // R6: top address saturates
      bus_start(); send_byte(8'hA0, ack); send_byte(8'h7F, ack);
      send_byte(8'h01, ack); send_byte(8'h02, ack);
      bus_stop();
      check(last_wa == 7'h7F && rf[7'h7F] == 8'h02, "R6 top saturate", last_wa, 7'h7F);
      check(wmask[0] == 1'b0, "R6 no wrap to zero", wmask[0], 0);
      bus_start(); send_byte(8'hA1, ack);
      recv_byte(1'b1, d);
      check(d == 8'h02, "R6 top read 1", d, 8'h02);
      recv_byte(1'b0, d);
      check(d == 8'h02, "R6 top read 2", d, 8'h02);
      bus_stop();

      // R6: font register holds pointer, font pointer steps
      bus_start(); send_byte(8'hA0, ack); send_byte(8'h05, ack);
      send_byte(8'hA1, ack); send_byte(8'hA2, ack); send_byte(8'hA3, ack);
      bus_stop();
      check(font_ptr == 7'd3, "R6 font pointer after writes", font_ptr, 3);
      check(last_wa == 7'h05 && rf[7'h05] == 8'hA3, "R6 pointer held at font", last_wa, 5);
      bus_start(); send_byte(8'hA1, ack);
      recv_byte(1'b0, d);
      bus_stop();
      check(d == 8'hA3 && font_ptr == 7'd4, "R6 font read", d, 8'hA3);

      // R7: reserved register write dropped, pointer then moves to 0x07 (R5)
      base = wr_cnt;
      bus_start(); send_byte(8'hA0, ack); send_byte(8'h06, ack);
      send_byte(8'h99, ack);
      check(ack, "R7 reserved byte still acked", ack, 1);
      send_byte(8'h44, ack);
      bus_stop();
      check(wmask[6] == 1'b0 && wr_cnt == base + 1, "R7 no reserved write", wr_cnt - base, 1);
      check(rf[7'h07] == 8'h44, "R5 step past reserved", rf[7'h07], 8'h44);

      // R3: command byte then STOP stores only the pointer
      base = wr_cnt;
      bus_start(); send_byte(8'hA0, ack); send_byte(8'hB0, ack);
      bus_stop();
      check(wr_cnt == base, "R3 pointer-only write", wr_cnt - base, 0);
      bus_start(); send_byte(8'hA1, ack);
      recv_byte(1'b0, d);
      bus_stop();
      check(d == 8'h95, "R3 read from stored pointer", d, 8'h95);

      // R9: repeated START keeps pointer; R4 read autoincrement
      bus_start(); send_byte(8'hA0, ack); send_byte(8'h21, ack);
      bus_start(); send_byte(8'hA1, ack);
      check(ack, "R9 read address after repeated start", ack, 1);
      recv_byte(1'b1, d);
      check(d == 8'h55, "R9 first read byte", d, 8'h55);
      recv_byte(1'b0, d);
      check(d == 8'h87, "R4 read increment", d, 8'h87);

      // R10: after NACK the line stays released through further clocks
      waitc(2);
      check(sda_oe == 1'b0, "R10 release after nack", sda_oe, 0);
      send_byte(8'h00, ack);
      check(!ack && sda_oe == 1'b0, "R10 clocks ignored", ack, 0);
      bus_stop();
      check(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule